// File: doc/BRIEF.md
# Chip-Select Bank Controller

This block is one bank of an external memory controller. At each transfer-start it compares the internal bus address and address type against a programmed base, under per-bit masks. On a match it runs the external cycle. It holds chip select and the byte-lane strobes for the whole transfer. It counts wait states and acknowledges each data beat. For bursts, it drives a burst-in-progress strobe.

The strobe behaviour is set by configuration inputs:

- The lane strobes can act as write enables or as byte enables.
- The burst strobe has three timing modes.
- Acknowledge can come from the internal wait-state counter or from an external device.

Writes to a write-protected bank are refused. The bank stays deselected and gives no acknowledge. A sticky error flag is set, and a one-cycle transfer-error request is raised for a bus monitor outside the block. Setting the late and toggle burst-strobe modes together is illegal. That combination is reported on a status output, and the block uses normal timing instead.

Top module: `cs_bank_ctrl`

## Requirements
- R1: The bank matches when `((addr_i ^ cfg_base_i) & cfg_amask_i) == 0` and `((atype_i ^ cfg_atype_i) & cfg_atmask_i) == 0`. A mask bit of 1 means that bit is compared. Without a match, a transfer-start leaves `cs_o` low.
- R2: Port size code 00 is a 32-bit port, and lanes 3..0 follow `byte_sel_i`. Code 10 is a 16-bit port, and only lanes 1..0 are used. Code 01 is an 8-bit port, and only lane 0 is used. Code 11 is reserved, and the bank never matches.
- R3: A transfer has 1 beat. It has 4 beats when `burst_i` and `burst_en_i` are both high and `cfg_blen8_i` is 0. It has 8 beats when `burst_i` and `burst_en_i` are both high and `cfg_blen8_i` is 1. When `burst_en_i` is low, a burst request gives a single beat.
- R4: Counting the cycle after the start edge as cycle 1, with W = `cfg_ws_i` (0..15), beat k is acknowledged in cycle 1+W+k(W+1). `cs_o` is high in cycles 1..N(W+1) and low afterwards.
- R5: With `cfg_ext_ack_i` set, `ack_o` stays low and `cfg_ws_i` is ignored. Each beat ends in the cycle in which `ext_ack_i` is high.
- R6: With `cfg_byte_en_i` = 0, `strb_o` shows the active lanes on writes only (write enables). With `cfg_byte_en_i` = 1, it shows them on reads and writes (byte enables).
- R7: In normal timing, `burst_act_o` is high in every cycle of a multi-beat transfer except the cycles of its last beat. It is always low for single beats.
- R8: In late timing (`cfg_late_i` = 1, `cfg_toggle_i` = 0), `burst_act_o` is low during the first beat's wait states and rises in that beat's acknowledge cycle. It is otherwise as in R7.
- R9: In toggle timing (`cfg_toggle_i` = 1, `cfg_late_i` = 0), `burst_act_o` is as in R7 but low in each beat's acknowledge cycle.
- R10: `cfg_err_o` is high whenever `cfg_late_i` and `cfg_toggle_i` are both set. The burst strobe then follows R7.
- R11: A matching write with `cfg_wp_i` = 1 keeps `cs_o`, `ack_o` and `strb_o` low. It sets `wperr_o` and pulses `tea_req_o` for one cycle, both in cycle 1. Protected reads proceed normally.
- R12: `wperr_o` is sticky and is cleared only by `wperr_clr_i`. A new error in the same cycle wins over the clear.
- R13: A transfer-start while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 17 | Compared address bits |
| atype_i | input | 3 | Address type of the access |
| wr_i | input | 1 | 1 = write |
| ts_i | input | 1 | Transfer start, one cycle |
| burst_i | input | 1 | Burst requested |
| byte_sel_i | input | 4 | Byte lanes the access uses |
| cfg_base_i | input | 17 | Base address |
| cfg_amask_i | input | 17 | Address compare mask |
| cfg_atype_i | input | 3 | Address type to match |
| cfg_atmask_i | input | 3 | Address type compare mask |
| cfg_psize_i | input | 2 | Port size code |
| cfg_wp_i | input | 1 | Write protect |
| cfg_blen8_i | input | 1 | Burst length 8 (else 4) |
| burst_en_i | input | 1 | Global controller burst enable |
| cfg_byte_en_i | input | 1 | Strobes as byte enables |
| cfg_late_i | input | 1 | Late burst-strobe timing |
| cfg_toggle_i | input | 1 | Toggle burst-strobe timing |
| cfg_ext_ack_i | input | 1 | Acknowledge from external device |
| cfg_ws_i | input | 4 | Wait states per beat |
| ext_ack_i | input | 1 | External acknowledge |
| wperr_clr_i | input | 1 | Clear write-protect error |
| cs_o | output | 1 | Chip select |
| strb_o | output | 4 | Write-enable or byte-enable lanes |
| burst_act_o | output | 1 | Burst data in progress |
| ack_o | output | 1 | Transfer acknowledge |
| wperr_o | output | 1 | Sticky write-protect error |
| tea_req_o | output | 1 | Transfer-error request |
| cfg_err_o | output | 1 | Illegal strobe-timing configuration |

## Verification
The hardest case to reach is the burst strobe around beat boundaries. It requires late or toggle timing, bursts of 4 or 8 beats, nonzero wait states or externally paced beats, and a second transfer-start arriving partway through. The bench runs one task that drives a transfer and compares every output on every cycle against a position formula. Beat index and in-beat position come from the cycle number and the wait count, and external acknowledges are placed with the same formula. Mode, length, wait count, direction and port size are then swept across that task.

// File: rtl/cs_bank_pkg.sv
`timescale 1ns/1ps
package cs_bank_pkg;
  localparam int unsigned SHORT_BEATS = 4;
  localparam int unsigned LONG_BEATS  = 8;
  localparam int unsigned BEAT_W      = $clog2(LONG_BEATS);

  typedef enum logic [1:0] {
    PS_32  = 2'b00,
    PS_8   = 2'b01,
    PS_16  = 2'b10,
    PS_RSV = 2'b11
  } psize_e;

  typedef struct packed {
    logic wr;
    logic be_mode;
    logic late;
    logic tog;
  } strb_cfg_t;
endpackage

// File: rtl/cs_addr_match.sv
`timescale 1ns/1ps
module cs_addr_match
  import cs_bank_pkg::*;
#(
  parameter int unsigned AW    = 17,
  parameter int unsigned TW    = 3,
  parameter int unsigned LANES = 4
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [TW-1:0]    atype_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    amask_i,
  input  logic [TW-1:0]    tbase_i,
  input  logic [TW-1:0]    tmask_i,
  input  logic [1:0]       psize_i,
  input  logic [LANES-1:0] byte_sel_i,
  output logic             hit_o,
  output logic [LANES-1:0] lanes_o
);
  localparam int unsigned HALF = (LANES > 1) ? LANES / 2 : 1;

  logic [LANES-1:0] size_mask;

  always_comb begin
    size_mask = '0;
    unique case (psize_e'(psize_i))
      PS_32:   size_mask = '1;
      PS_16:   size_mask[HALF-1:0] = '1;
      PS_8:    size_mask[0] = 1'b1;
      default: size_mask = '0;
    endcase
  end

  assign hit_o   = (((addr_i ^ base_i) & amask_i) == '0) &&
                   (((atype_i ^ tbase_i) & tmask_i) == '0) &&
                   (psize_i != PS_RSV);
  assign lanes_o = byte_sel_i & size_mask;
endmodule

// File: rtl/cs_beat_seq.sv
`timescale 1ns/1ps
module cs_beat_seq #(
  parameter int unsigned WS_W   = 4,
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [BEAT_W-1:0] last_i,
  input  logic              ext_i,
  input  logic              ext_ack_i,
  output logic              active_o,
  output logic              done_o,
  output logic              first_o,
  output logic              last_o
);
  logic              active_q, ext_q;
  logic [WS_W-1:0]   ws_q, wcnt_q;
  logic [BEAT_W-1:0] idx_q, last_q;

  assign active_o = active_q;
  assign done_o   = active_q && (ext_q ? ext_ack_i : (wcnt_q == '0));
  assign first_o  = (idx_q == '0);
  assign last_o   = (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ext_q    <= 1'b0;
      ws_q     <= '0;
      wcnt_q   <= '0;
      idx_q    <= '0;
      last_q   <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        ext_q    <= ext_i;
        ws_q     <= ws_i;
        wcnt_q   <= ws_i;
        idx_q    <= '0;
        last_q   <= last_i;
      end
    end else if (done_o) begin
      if (last_o) active_q <= 1'b0;
      idx_q  <= idx_q + 1'b1;
      wcnt_q <= ws_q;
    end else if (!ext_q && wcnt_q != '0) begin
      wcnt_q <= wcnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cs_bank_ctrl.sv
`timescale 1ns/1ps
module cs_bank_ctrl
  import cs_bank_pkg::*;
#(
  parameter int unsigned AW    = 17,
  parameter int unsigned TW    = 3,
  parameter int unsigned WS_W  = 4,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [TW-1:0]    atype_i,
  input  logic             wr_i,
  input  logic             ts_i,
  input  logic             burst_i,
  input  logic [LANES-1:0] byte_sel_i,
  input  logic [AW-1:0]    cfg_base_i,
  input  logic [AW-1:0]    cfg_amask_i,
  input  logic [TW-1:0]    cfg_atype_i,
  input  logic [TW-1:0]    cfg_atmask_i,
  input  logic [1:0]       cfg_psize_i,
  input  logic             cfg_wp_i,
  input  logic             cfg_blen8_i,
  input  logic             burst_en_i,
  input  logic             cfg_byte_en_i,
  input  logic             cfg_late_i,
  input  logic             cfg_toggle_i,
  input  logic             cfg_ext_ack_i,
  input  logic [WS_W-1:0]  cfg_ws_i,
  input  logic             ext_ack_i,
  input  logic             wperr_clr_i,
  output logic             cs_o,
  output logic [LANES-1:0] strb_o,
  output logic             burst_act_o,
  output logic             ack_o,
  output logic             wperr_o,
  output logic             tea_req_o,
  output logic             cfg_err_o
);
  localparam logic [BEAT_W-1:0] LAST_SHORT = BEAT_W'(SHORT_BEATS - 1);
  localparam logic [BEAT_W-1:0] LAST_LONG  = BEAT_W'(LONG_BEATS - 1);

  logic             hit, active, done, first, last;
  logic             start, wp_hit;
  logic [LANES-1:0] lanes, lanes_q;
  logic [BEAT_W-1:0] last_idx;
  strb_cfg_t        scfg_q;
  logic             wperr_q, tea_q, ext_q;

  cs_addr_match #(.AW(AW), .TW(TW), .LANES(LANES)) u_match (
    .addr_i    (addr_i),
    .atype_i   (atype_i),
    .base_i    (cfg_base_i),
    .amask_i   (cfg_amask_i),
    .tbase_i   (cfg_atype_i),
    .tmask_i   (cfg_atmask_i),
    .psize_i   (cfg_psize_i),
    .byte_sel_i(byte_sel_i),
    .hit_o     (hit),
    .lanes_o   (lanes)
  );

  // a start seen while busy is dropped
  assign start  = ts_i && hit && !active && !(wr_i && cfg_wp_i);
  assign wp_hit = ts_i && hit && !active && wr_i && cfg_wp_i;

  always_comb begin
    last_idx = '0;
    if (burst_i && burst_en_i) last_idx = cfg_blen8_i ? LAST_LONG : LAST_SHORT;
  end

  cs_beat_seq #(.WS_W(WS_W), .BEAT_W(BEAT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .ws_i     (cfg_ws_i),
    .last_i   (last_idx),
    .ext_i    (cfg_ext_ack_i),
    .ext_ack_i(ext_ack_i),
    .active_o (active),
    .done_o   (done),
    .first_o  (first),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scfg_q  <= '0;
      lanes_q <= '0;
      ext_q   <= 1'b0;
    end else if (start) begin
      scfg_q.wr      <= wr_i;
      scfg_q.be_mode <= cfg_byte_en_i;
      // illegal late+toggle falls back to normal timing
      scfg_q.late    <= cfg_late_i && !cfg_toggle_i;
      scfg_q.tog     <= cfg_toggle_i && !cfg_late_i;
      lanes_q        <= lanes;
      ext_q          <= cfg_ext_ack_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wperr_q <= 1'b0;
      tea_q   <= 1'b0;
    end else begin
      tea_q <= wp_hit;
      if (wp_hit)           wperr_q <= 1'b1;
      else if (wperr_clr_i) wperr_q <= 1'b0;
    end
  end

  always_comb begin
    burst_act_o = 1'b0;
    if (active && !last) begin
      if (scfg_q.late)     burst_act_o = !first || done;
      else if (scfg_q.tog) burst_act_o = !done;
      else                 burst_act_o = 1'b1;
    end
  end

  assign cs_o      = active;
  assign strb_o    = (active && (scfg_q.be_mode || scfg_q.wr)) ? lanes_q : '0;
  assign ack_o     = done && !ext_q;
  assign wperr_o   = wperr_q;
  assign tea_req_o = tea_q;
  assign cfg_err_o = cfg_late_i && cfg_toggle_i;
endmodule

// File: rtl/cs_bank_chk.sv
`timescale 1ns/1ps
module cs_bank_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_o,
  input logic [LANES-1:0] strb_o,
  input logic             burst_act_o,
  input logic             ack_o,
  input logic             wperr_o,
  input logic             tea_req_o,
  input logic             wperr_clr_i
);
  // R4
  ack_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cs_o);
  // R7
  bact_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_act_o |-> cs_o);
  // R6
  strb_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_o != '0) |-> cs_o);
  // R11
  tea_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_req_o |-> (!cs_o && !ack_o && wperr_o));
  // R12
  wperr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wperr_o) |-> tea_req_o);
  // R12
  wperr_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wperr_o) |-> $past(wperr_clr_i));
endmodule

bind cs_bank_ctrl cs_bank_chk #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_o       (cs_o),
  .strb_o     (strb_o),
  .burst_act_o(burst_act_o),
  .ack_o      (ack_o),
  .wperr_o    (wperr_o),
  .tea_req_o  (tea_req_o),
  .wperr_clr_i(wperr_clr_i)
);

// File: tb/sim_cs_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cs_bank_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [16:0] addr_i = '0, cfg_base_i = 17'h0A5C3, cfg_amask_i = '1;
  logic [2:0]  atype_i = 3'b010, cfg_atype_i = 3'b010, cfg_atmask_i = 3'b111;
  logic        wr_i = 0, ts_i = 0, burst_i = 0, cfg_wp_i = 0, cfg_blen8_i = 0;
  logic        burst_en_i = 1, cfg_byte_en_i = 1, cfg_late_i = 0, cfg_toggle_i = 0;
  logic        cfg_ext_ack_i = 0, ext_ack_i = 0, wperr_clr_i = 0;
  logic [3:0]  byte_sel_i = 4'hF, cfg_ws_i = '0;
  logic [1:0]  cfg_psize_i = 2'b00;
  logic        cs_o, burst_act_o, ack_o, wperr_o, tea_req_o, cfg_err_o;
  logic [3:0]  strb_o;
  int          n_run = 0, n_fail = 0;
  bit          done_flag = 0;

  always #4 clk = ~clk;

  cs_bank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .atype_i(atype_i), .wr_i(wr_i),
    .ts_i(ts_i), .burst_i(burst_i), .byte_sel_i(byte_sel_i), .cfg_base_i(cfg_base_i),
    .cfg_amask_i(cfg_amask_i), .cfg_atype_i(cfg_atype_i), .cfg_atmask_i(cfg_atmask_i),
    .cfg_psize_i(cfg_psize_i), .cfg_wp_i(cfg_wp_i), .cfg_blen8_i(cfg_blen8_i),
    .burst_en_i(burst_en_i), .cfg_byte_en_i(cfg_byte_en_i), .cfg_late_i(cfg_late_i),
    .cfg_toggle_i(cfg_toggle_i), .cfg_ext_ack_i(cfg_ext_ack_i), .cfg_ws_i(cfg_ws_i),
    .ext_ack_i(ext_ack_i), .wperr_clr_i(wperr_clr_i), .cs_o(cs_o), .strb_o(strb_o),
    .burst_act_o(burst_act_o), .ack_o(ack_o), .wperr_o(wperr_o),
    .tea_req_o(tea_req_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] lanes_of(input logic [1:0] ps, input logic [3:0] bs);
    case (ps)
      2'b00:   return bs;
      2'b10:   return bs & 4'b0011;
      2'b01:   return bs & 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  // mode: 0 normal, 1 late, 2 toggle, 3 both (illegal)
  task automatic xfer(input string tag, input logic wr, input logic brst, input int w,
                      input int mode, input logic ext, input logic busy_ts);
    int n, t;
    logic [3:0] exp_strb;
    n = (brst && burst_en_i) ? (cfg_blen8_i ? 8 : 4) : 1;
    t = n * (w + 1);
    cfg_late_i = (mode == 1 || mode == 3);
    cfg_toggle_i = (mode == 2 || mode == 3);
    cfg_ext_ack_i = ext;
    cfg_ws_i = ext ? 4'(15 - w) : 4'(w);
    exp_strb = (cfg_byte_en_i || wr) ? lanes_of(cfg_psize_i, byte_sel_i) : 4'h0;
    @(negedge clk);
    ts_i = 1; wr_i = wr; burst_i = brst;
    for (int c = 1; c <= t + 1; c++) begin
      int pos, k;
      logic e_cs, e_ack, e_ba, lst, dn;
      @(negedge clk);
      ts_i = busy_ts && (c == 2);
      pos = (c - 1) % (w + 1);
      k = (c - 1) / (w + 1);
      e_cs = (c <= t);
      dn = e_cs && (pos == w);
      ext_ack_i = ext && dn;
      e_ack = dn && !ext;
      lst = (k == n - 1);
      e_ba = e_cs && n > 1 && !lst &&
             (mode == 1 ? (k > 0 || dn) : mode == 2 ? !dn : 1'b1);
      #1;
      check({tag, " cs"}, 32'(cs_o), 32'(e_cs));
      check({tag, " ack"}, 32'(ack_o), 32'(e_ack));
      check({tag, " bact"}, 32'(burst_act_o), 32'(e_ba));
      check({tag, " strb"}, 32'(strb_o), e_cs ? 32'(exp_strb) : 32'h0);
      if (c == 1) check("R10 cfg_err", 32'(cfg_err_o), 32'(mode == 3));
    end
    ts_i = 0; ext_ack_i = 0; burst_i = 0; wr_i = 0;
  endtask

  task automatic probe(input logic [16:0] a, input logic [2:0] at, input logic exp_hit);
    cfg_ws_i = 0; cfg_ext_ack_i = 0;
    @(negedge clk); addr_i = a; atype_i = at; ts_i = 1; wr_i = 0; burst_i = 0;
    @(negedge clk); ts_i = 0; #1;
    check("R1 match", 32'(cs_o), 32'(exp_hit));
    @(negedge clk); addr_i = cfg_base_i; atype_i = cfg_atype_i;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    if (!done_flag) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    addr_i = cfg_base_i;
    #20; #1;
    check("R4 reset cs", 32'(cs_o), 0);
    check("R12 reset wperr", 32'(wperr_o), 0);
    check("R11 reset tea", 32'(tea_req_o), 0);
    check("R6 reset strb", 32'(strb_o), 0);
    rst_ni = 1;

    // R1: address bits and type
    for (int b = 0; b < 17; b++) begin
      cfg_amask_i = '1;
      probe(cfg_base_i ^ (17'd1 << b), cfg_atype_i, 1'b0);
      cfg_amask_i = ~(17'd1 << b);
      probe(cfg_base_i ^ (17'd1 << b), cfg_atype_i, 1'b1);
    end
    cfg_amask_i = '1;
    for (int a = 0; a < 8; a++) begin
      cfg_atmask_i = 3'b111;
      probe(cfg_base_i, 3'(a), a == 2);
      cfg_atmask_i = 3'b000;
      probe(cfg_base_i, 3'(a), 1'b1);
    end
    cfg_atmask_i = 3'b111;

    // R2: port size
    cfg_psize_i = 2'b11;
    probe(cfg_base_i, cfg_atype_i, 1'b0);
    for (int p = 0; p < 3; p++) begin
      cfg_psize_i = 2'(p);
      xfer("R2", 1'b1, 1'b0, 1, 0, 1'b0, 1'b0);
    end
    cfg_psize_i = 2'b00;

    // R4: wait states on single beats
    for (int w = 0; w < 16; w++) xfer("R4", 1'b0, 1'b0, w, 0, 1'b0, 1'b0);

    // R3: burst lengths and global enable
    for (int l = 0; l < 2; l++) begin
      cfg_blen8_i = l[0];
      xfer("R3", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
      xfer("R3", 1'b1, 1'b1, 2, 0, 1'b0, 1'b0);
    end
    burst_en_i = 0;
    xfer("R3", 1'b0, 1'b1, 1, 0, 1'b0, 1'b0);
    burst_en_i = 1;

    // R7 R8 R9 R10: burst strobe modes
    for (int m = 0; m < 4; m++) begin
      cfg_blen8_i = 0;
      xfer(m == 0 ? "R7" : m == 1 ? "R8" : m == 2 ? "R9" : "R10", 1'b0, 1'b1, 2, m, 1'b0, 1'b0);
      cfg_blen8_i = 1;
      xfer(m == 0 ? "R7" : m == 1 ? "R8" : m == 2 ? "R9" : "R10", 1'b1, 1'b1, 1, m, 1'b0, 1'b0);
    end

    // R6: write-enable vs byte-enable
    byte_sel_i = 4'b0110;
    for (int be = 0; be < 2; be++) begin
      cfg_byte_en_i = be[0];
      xfer("R6", 1'b0, 1'b0, 1, 0, 1'b0, 1'b0);
      xfer("R6", 1'b1, 1'b0, 1, 0, 1'b0, 1'b0);
    end
    cfg_byte_en_i = 1; byte_sel_i = 4'hF;

    // R5: external acknowledge
    cfg_blen8_i = 0;
    for (int w = 0; w < 4; w++) xfer("R5", 1'b0, 1'b1, w, w % 3, 1'b1, 1'b0);
    xfer("R5", 1'b1, 1'b0, 5, 0, 1'b1, 1'b0);

    // R13: start while busy
    xfer("R13", 1'b0, 1'b1, 1, 0, 1'b0, 1'b1);
    xfer("R13", 1'b0, 1'b0, 3, 0, 1'b0, 1'b1);

    // R11 R12: write protect
    cfg_wp_i = 1; cfg_ws_i = 0; cfg_ext_ack_i = 0;
    @(negedge clk); ts_i = 1; wr_i = 1;
    @(negedge clk); ts_i = 0; wr_i = 0; #1;
    check("R11 cs", 32'(cs_o), 0);
    check("R11 ack", 32'(ack_o), 0);
    check("R11 strb", 32'(strb_o), 0);
    check("R11 tea", 32'(tea_req_o), 1);
    check("R11 wperr", 32'(wperr_o), 1);
    @(negedge clk); #1;
    check("R11 tea pulse", 32'(tea_req_o), 0);
    check("R12 sticky", 32'(wperr_o), 1);
    xfer("R11 read", 1'b0, 1'b0, 2, 0, 1'b0, 1'b0);
    check("R12 sticky after read", 32'(wperr_o), 1);
    @(negedge clk); wperr_clr_i = 1;
    @(negedge clk); wperr_clr_i = 0; #1;
    check("R12 clear", 32'(wperr_o), 0);
    @(negedge clk); ts_i = 1; wr_i = 1; wperr_clr_i = 1;
    @(negedge clk); ts_i = 0; wr_i = 0; wperr_clr_i = 0; #1;
    check("R12 set wins", 32'(wperr_o), 1);
    check("R11 tea again", 32'(tea_req_o), 1);
    cfg_wp_i = 0;
    @(negedge clk); wperr_clr_i = 1;
    @(negedge clk); wperr_clr_i = 0; #1;
    check("R12 clear again", 32'(wperr_o), 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule